// File: doc/BRIEF.md
# Two-Phase Burst Drive Generator

This block produces two square waves for one piezo motor's pair of half-bridge drivers. Both waves share a programmable period, counted in timebase ticks, and a programmable high time. The second wave is shifted a quarter period behind or ahead of the first, and a reverse flag picks which. A load strobe captures a new setting together with an 11-bit burst length. The block then emits exactly that many periods and drives both outputs low. A system with two motors uses two instances.

A load that carries a zero burst length stops the channel at once. A non-zero load that arrives during a burst takes effect at the next period boundary, so the motor never sees a truncated cycle. An active-low power-down input silences the outputs in the same cycle and clears the channel. A per-channel doubling flag advances the timebase by two ticks per input clock. With it, a clock at half the nominal rate gives the same output frequencies.

Top module: `quad_burst_gen`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `busy`, `phase_a` and `phase_b` are low.
- R2: With `tick_x2`=0, a non-zero load makes `busy` high from the load edge onward. Within a burst, the tick position starts at 0 in the cycle after the load edge and advances by one per clock. A period lasts `period_cnt` ticks.
- R3: `phase_a` is high while the tick position is below the high time. The high time is floor(`period_cnt`/2) ticks when `duty_cnt` is 0, and `duty_cnt` ticks otherwise.
- R4: `phase_b` has the same high time. Its window starts floor(P/4) ticks after `phase_a`'s when `reverse`=0, and P−floor(P/4) ticks after when `reverse`=1, taken modulo P.
- R5: A burst of N periods keeps `busy` high for exactly N·P cycles, counting the cycle after the load edge as the first. Afterwards both phases are low.
- R6: A load with `pulse_cnt`=0 clears `busy` and both phases in the cycle after its edge, even mid-burst. They stay low until the next non-zero load.
- R7: While `pd_n` is low both phases are low in the same cycle. `busy` is low after the next edge, and loads are ignored.
- R8: With `tick_x2`=1 the position advances two ticks per clock, wrapping modulo P. A burst of N periods lasts ceil(N·P/2) cycles. This holds for an 11-bit count with its top bit set (1024).
- R9: A non-zero load during a burst does not cut the current period short. At the next period boundary the new period, duty, direction and count take over from position 0, and `busy` stays high throughout.
- R10: A burst started from idle after a previous one ended follows R2 to R5 with its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_n | input | 1 | Power-down, active low |
| load | input | 1 | Capture the setting inputs this cycle |
| period_cnt | input | 8 | Period in timebase ticks |
| duty_cnt | input | 8 | High time in ticks, 0 selects half period |
| pulse_cnt | input | 11 | Number of periods, 0 aborts |
| reverse | input | 1 | 0: phase_b lags a quarter, 1: leads |
| tick_x2 | input | 1 | Advance the timebase two ticks per clock |
| phase_a | output | 1 | First drive wave |
| phase_b | output | 1 | Second drive wave |
| busy | output | 1 | Burst in progress |

## Verification
A corrupted tick position or period register shows at the ports within one period. The edges of both waves move against the tick-by-tick model in the bench, which compares every cycle of every burst. A wrong remaining-period count, or a pending setting handled at the wrong moment, shifts the fall of `busy` by whole periods. The bench measures that fall exactly to the cycle. Abort and power-down faults show up one cycle after the triggering edge.

// File: rtl/qbg_pkg.sv
`timescale 1ns/1ps
// Shared widths and the active-setting record of the burst generator.
// Assumes a period of at least 4 ticks so that a quarter offset exists.
package qbg_pkg;
    parameter int PER_W = 8;   // width of period and duty fields
    parameter int CNT_W = 11;  // width of the burst length

    typedef struct packed {
        logic [PER_W-1:0] per;      // period in ticks
        logic [PER_W-1:0] high;     // high time in ticks
        logic [PER_W-1:0] b_start;  // start of phase_b window
        logic             x2;       // two ticks per clock
    } qbg_cfg_t;

    // Turn raw inputs into the decoded setting, done once at capture time.
    function automatic qbg_cfg_t make_cfg(input logic [PER_W-1:0] per,
                                          input logic [PER_W-1:0] duty,
                                          input logic rev,
                                          input logic x2);
        qbg_cfg_t c;
        logic [PER_W-1:0] quarter;
        quarter   = per >> 2;
        c.per     = per;
        c.high    = (duty == '0) ? (per >> 1) : duty;
        c.b_start = rev ? (per - quarter) : quarter;
        c.x2      = x2;
        return c;
    endfunction
endpackage

// File: rtl/qbg_timebase.sv
`timescale 1ns/1ps
// Tick position counter. Holds 0 while idle, steps by 1 or 2 per clock
// while running and wraps modulo the period, flagging each wrap.
// Assumes period >= 2 when stepping by two.
module qbg_timebase
    import qbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] per,
    input  logic             x2,
    output logic [PER_W-1:0] pos,
    output logic             wrap
);
    logic [PER_W:0] nxt;

    // Next position and period-boundary detection.
    always_comb begin
        nxt  = {1'b0, pos} + (x2 ? (PER_W+1)'(2) : (PER_W+1)'(1));
        wrap = run && (nxt >= {1'b0, per});
    end

    // Position register: cleared when idle, wrapped at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            pos <= '0;
        else if (wrap)
            pos <= PER_W'(nxt - {1'b0, per});
        else
            pos <= PER_W'(nxt);
    end
endmodule

// File: rtl/qbg_burst_ctrl.sv
`timescale 1ns/1ps
// Burst sequencer: captures settings, counts remaining periods, holds a
// pending setting for a retrigger and applies it at a period boundary.
// Assumes wrap comes from the timebase driven by this block's run.
module qbg_burst_ctrl
    import qbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             load,
    input  logic [PER_W-1:0] period_cnt,
    input  logic [PER_W-1:0] duty_cnt,
    input  logic [CNT_W-1:0] pulse_cnt,
    input  logic             reverse,
    input  logic             tick_x2,
    input  logic             wrap,
    output logic             run,
    output qbg_cfg_t         act
);
    qbg_cfg_t         pend;
    logic             pend_v;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] pend_cnt;
    qbg_cfg_t         new_cfg;
    logic             last_wrap;

    // Decode incoming setting and detect the final boundary of a burst.
    always_comb begin
        new_cfg   = make_cfg(period_cnt, duty_cnt, reverse, tick_x2);
        last_wrap = run && wrap && !pend_v && (remain == CNT_W'(1));
    end

    // Sequencer state: start, abort, count down, retrigger.
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_n) begin
            run      <= 1'b0;
            pend_v   <= 1'b0;
            remain   <= '0;
            pend_cnt <= '0;
            act      <= '0;
            pend     <= '0;
        end else if (load && (pulse_cnt == '0)) begin
            run    <= 1'b0;
            pend_v <= 1'b0;
        end else if (load && (!run || last_wrap)) begin
            run    <= 1'b1;
            act    <= new_cfg;
            remain <= pulse_cnt;
            pend_v <= 1'b0;
        end else begin
            if (run && wrap) begin
                if (pend_v) begin
                    act    <= pend;
                    remain <= pend_cnt;
                    pend_v <= 1'b0;
                end else if (remain == CNT_W'(1)) begin
                    run <= 1'b0;
                end else begin
                    remain <= remain - CNT_W'(1);
                end
            end
            if (load) begin
                pend_v   <= 1'b1;
                pend     <= new_cfg;
                pend_cnt <= pulse_cnt;
            end
        end
    end
endmodule

// File: rtl/qbg_phase_decode.sv
`timescale 1ns/1ps
// Window decode of both drive waves from the tick position.
// Assumes pos < per and b_start <= per; gating by pd_n is immediate.
module qbg_phase_decode
    import qbg_pkg::*;
(
    input  logic             pd_n,
    input  logic             run,
    input  logic [PER_W-1:0] pos,
    input  qbg_cfg_t         cfg,
    output logic             phase_a,
    output logic             phase_b
);
    logic [PER_W:0] rel_b;

    // Position relative to phase_b's window start, modulo the period.
    always_comb begin
        if (pos >= cfg.b_start)
            rel_b = {1'b0, pos - cfg.b_start};
        else
            rel_b = {1'b0, pos} + {1'b0, cfg.per} - {1'b0, cfg.b_start};
    end

    // Output windows, forced low when idle or powered down.
    always_comb begin
        phase_a = pd_n && run && (pos < cfg.high);
        phase_b = pd_n && run && (rel_b < {1'b0, cfg.high});
    end
endmodule

// File: rtl/quad_burst_gen.sv
`timescale 1ns/1ps
// One channel of a two-phase burst drive: sequencer, timebase and
// window decode. Assumes settings are stable in the cycle of load.
module quad_burst_gen
    import qbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             load,
    input  logic [PER_W-1:0] period_cnt,
    input  logic [PER_W-1:0] duty_cnt,
    input  logic [CNT_W-1:0] pulse_cnt,
    input  logic             reverse,
    input  logic             tick_x2,
    output logic             phase_a,
    output logic             phase_b,
    output logic             busy
);
    qbg_cfg_t         act_cfg;
    logic             run;
    logic             wrap;
    logic [PER_W-1:0] pos_q;
    logic [PER_W-1:0] act_per;

    qbg_burst_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .load(load),
        .period_cnt(period_cnt), .duty_cnt(duty_cnt), .pulse_cnt(pulse_cnt),
        .reverse(reverse), .tick_x2(tick_x2), .wrap(wrap),
        .run(run), .act(act_cfg)
    );

    qbg_timebase u_tb (
        .clk(clk), .rst_n(rst_n), .run(run), .per(act_cfg.per),
        .x2(act_cfg.x2), .pos(pos_q), .wrap(wrap)
    );

    qbg_phase_decode u_dec (
        .pd_n(pd_n), .run(run), .pos(pos_q), .cfg(act_cfg),
        .phase_a(phase_a), .phase_b(phase_b)
    );

    assign act_per = act_cfg.per;
    assign busy    = run;
endmodule

// File: rtl/qbg_checker.sv
`timescale 1ns/1ps
// Temporal checks on the burst generator, bound to its top module.
module qbg_checker
    import qbg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pd_n,
    input logic             load,
    input logic [CNT_W-1:0] pulse_cnt,
    input logic             busy,
    input logic [PER_W-1:0] pos,
    input logic [PER_W-1:0] per
);
    // R2: the timebase never leaves the active period.
    a_r2_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pos < per));

    // R2, R9: a non-zero load leaves the channel busy.
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && load && (pulse_cnt != '0)) |=> busy);

    // R6: a zero length stops the channel on the next edge.
    a_r6_zero_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && load && (pulse_cnt == '0)) |=> !busy);

    // R7: power-down clears the channel on the next edge.
    a_r7_pd_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> !busy);
endmodule

bind quad_burst_gen qbg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .load(load),
    .pulse_cnt(pulse_cnt), .busy(busy), .pos(pos_q), .per(act_per)
);

// File: tb/tb_quad_burst_gen.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_quad_burst_gen;
    logic        clk = 1'b0;
    logic        rst_n, pd_n, load, reverse, tick_x2;
    logic [7:0]  period_cnt, duty_cnt;
    logic [10:0] pulse_cnt;
    logic        phase_a, phase_b, busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    quad_burst_gen dut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .load(load),
        .period_cnt(period_cnt), .duty_cnt(duty_cnt), .pulse_cnt(pulse_cnt),
        .reverse(reverse), .tick_x2(tick_x2),
        .phase_a(phase_a), .phase_b(phase_b), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_a(input int t, input int p, input int duty);
        int h = (duty == 0) ? p / 2 : duty;
        return t < h;
    endfunction

    function automatic bit exp_b(input int t, input int p, input int duty, input bit rev);
        int h = (duty == 0) ? p / 2 : duty;
        int s = rev ? p - p / 4 : p / 4;
        int d = (t >= s) ? t - s : t + p - s;
        return d < h;
    endfunction

    // Apply one load; returns at the falling edge after the load edge.
    task automatic do_load(input int p, input int duty, input int cnt,
                           input bit rev, input bit x2);
        @(negedge clk);
        period_cnt = 8'(p);
        duty_cnt   = 8'(duty);
        pulse_cnt  = 11'(cnt);
        reverse    = rev;
        tick_x2    = x2;
        load       = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic t_reset();
        check(!busy, "R1", "busy after reset", int'(busy), 0);
        check(!phase_a && !phase_b, "R1", "phases after reset",
              int'({phase_a, phase_b}), 0);
    endtask

    // Full burst compared tick by tick (R2 R3 R4 R5 R8 R10).
    task automatic run_burst(input string tag, input int p, input int duty,
                             input int cnt, input bit rev, input bit x2);
        int t = 0, k = 0, bad = 0, first_k = -1;
        int exp_len = x2 ? (cnt * p + 1) / 2 : cnt * p;
        int act_ab = 0, exp_ab = 0;
        do_load(p, duty, cnt, rev, x2);
        while (busy && k < 150000) begin
            bit ea = exp_a(t, p, duty);
            bit eb = exp_b(t, p, duty, rev);
            if (phase_a !== ea || phase_b !== eb) begin
                if (bad == 0) begin
                    first_k = k;
                    act_ab  = int'({phase_a, phase_b});
                    exp_ab  = int'({ea, eb});
                end
                bad++;
            end
            t = t + (x2 ? 2 : 1);
            if (t >= p) t = t - p;
            @(negedge clk);
            k++;
        end
        check(bad == 0, tag, $sformatf("waves at cycle %0d", first_k), act_ab, exp_ab);
        check(k == exp_len, tag, "busy cycles", k, exp_len);
        check(!phase_a && !phase_b, tag, "phases after burst",
              int'({phase_a, phase_b}), 0);
    endtask

    // R6: zero count aborts mid-burst and stays quiet.
    task automatic t_abort();
        int stray = 0;
        do_load(120, 0, 100, 1'b0, 1'b0);
        repeat (30) @(negedge clk);
        check(busy, "R6", "busy before abort", int'(busy), 1);
        do_load(120, 0, 0, 1'b0, 1'b0);
        check(!busy && !phase_a && !phase_b, "R6", "state after abort",
              int'({busy, phase_a, phase_b}), 0);
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (busy || phase_a || phase_b) stray++;
        end
        check(stray == 0, "R6", "activity after abort", stray, 0);
    endtask

    // R7: power-down gates at once, clears busy, ignores loads.
    task automatic t_powerdown();
        do_load(120, 0, 5, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(phase_a, "R7", "phase_a high before power-down", int'(phase_a), 1);
        pd_n = 1'b0;
        #1;
        check(!phase_a && !phase_b, "R7", "phases same cycle",
              int'({phase_a, phase_b}), 0);
        @(negedge clk);
        check(!busy, "R7", "busy after edge", int'(busy), 0);
        do_load(120, 0, 5, 1'b0, 1'b0);
        check(!busy, "R7", "load ignored while down", int'(busy), 0);
        pd_n = 1'b1;
        @(negedge clk);
        check(!busy && !phase_a, "R7", "idle after release",
              int'({busy, phase_a}), 0);
    endtask

    // R9: retrigger applies at the next boundary.
    task automatic t_retrig();
        int bad = 0, k = 0, act_ab = 0, exp_ab = 0;
        do_load(120, 0, 3, 1'b0, 1'b0);
        while (busy && k < 2000) begin
            bit ea, eb;
            if (k < 120) begin
                ea = exp_a(k, 120, 0);
                eb = exp_b(k, 120, 0, 1'b0);
            end else begin
                ea = exp_a((k - 120) % 130, 130, 20);
                eb = exp_b((k - 120) % 130, 130, 20, 1'b1);
            end
            if ((phase_a !== ea || phase_b !== eb) && bad++ == 0) begin
                act_ab = int'({phase_a, phase_b});
                exp_ab = int'({ea, eb});
            end
            if (k == 50) begin
                period_cnt = 8'd130;
                duty_cnt   = 8'd20;
                pulse_cnt  = 11'd2;
                reverse    = 1'b1;
                load       = 1'b1;
            end
            if (k == 51) load = 1'b0;
            @(negedge clk);
            k++;
        end
        check(bad == 0, "R9", "waves across retrigger", act_ab, exp_ab);
        check(k == 380, "R9", "busy cycles with retrigger", k, 380);
    endtask

    initial begin
        #(4 * 300000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pd_n = 1'b1; load = 1'b0; reverse = 1'b0; tick_x2 = 1'b0;
        period_cnt = 8'd0; duty_cnt = 8'd0; pulse_cnt = 11'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_burst("R2 R3 R5 half duty", 120, 0, 3, 1'b0, 1'b0);
        run_burst("R3 R4 duty13 reverse", 133, 13, 2, 1'b1, 1'b0);
        run_burst("R3 R4 duty67 lag", 133, 67, 2, 1'b0, 1'b0);
        run_burst("R5 R10 single period", 111, 0, 1, 1'b1, 1'b0);
        run_burst("R8 doubled odd period", 133, 30, 3, 1'b0, 1'b1);
        run_burst("R8 doubled count 1024", 112, 0, 1024, 1'b1, 1'b1);
        t_abort();
        t_powerdown();
        run_burst("R10 after power-down", 143, 0, 2, 1'b0, 1'b0);
        t_retrig();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule